// File: doc/BRIEF.md
# Quad DAC Parallel Bus Sequencer

This block sits on the host side of a four-channel, 12-bit parallel-input converter. It turns one command at a time into correctly timed bus activity. A command names a channel, a 12-bit code, an operation and a buffering choice. The sequencer then drives the active-low chip select, the read/write direction line, the channel address, the data bus with its output enable, the active-low load strobe and the active-low converter reset. Every strobe is held low for a whole number of clock cycles. That number is derived from a minimum width in nanoseconds and the clock period, rounded up.

Writes can work in two ways. In double-buffered use, the host writes the channels one after another with the load strobe left high, then issues one load command that moves all four staged codes to the outputs together. In single-buffered use, the load strobe falls with chip select, so the addressed output follows the new code at once. A read-back raises the direction line, releases the data bus and samples the converter's data while chip select is still low. Every command ends with a one-cycle done pulse. For a read-back, the sampled code is presented alongside that pulse.

Top module: `dacbus_seq`

## Requirements
- R1: After reset the outputs sit at these values: chip select, load strobe and converter reset high, direction high (read), data output enable low, done low, read-back data zero, and command ready high.
- R2: A command is accepted on a clock edge where command valid and command ready are both high. Ready is low from that edge until the done cycle has passed. Valid raised while ready is low is ignored: it produces no bus activity and no done pulse.
- R3: A write (operation code 0) with the single-buffer flag at 0 does four things. It holds chip select low for exactly ceil(WR_NS/CLK_NS) cycles. It drives the direction line low (0 = write). It enables the data bus carrying the 12-bit code (bit 11 is the MSB) and puts the channel number on the address (0 to 3 for channels A to D). It leaves the load strobe high, so the outputs keep their previous codes.
- R4: A write with the single-buffer flag at 1 holds chip select and the load strobe low together for exactly max(ceil(WR_NS/CLK_NS), ceil(LD_NS/CLK_NS)) cycles, so the addressed output takes the new code.
- R5: A read-back (operation code 1) holds chip select low for exactly ceil(RD_NS/CLK_NS) cycles with the direction line high and the data bus released. The read-back data output shows the bus input as sampled in the last cycle of that low time. It stays there until the next read-back completes.
- R6: A global load (operation code 2) holds the load strobe low for exactly ceil(LD_NS/CLK_NS) cycles while chip select stays high.
- R7: A converter reset (operation code 3) holds the reset line low for exactly RST_CYC cycles, with chip select and the load strobe high throughout.
- R8: The done pulse lasts one cycle. It comes in the first cycle after the strobe returns high, with every strobe high at that point.
- R9: While chip select is low, the address, the direction line and the data bus value do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_op_i | input | 2 | Operation: 0 write, 1 read-back, 2 global load, 3 converter reset |
| cmd_ch_i | input | CH_W (2) | Channel number |
| cmd_code_i | input | CODE_W (12) | Code to write |
| cmd_single_i | input | 1 | 1 = single-buffered write, 0 = double-buffered write |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | CODE_W (12) | Last read-back code |
| bus_cs_no | output | 1 | Active-low chip select |
| bus_rw_o | output | 1 | Direction, 1 = read, 0 = write |
| bus_addr_o | output | CH_W (2) | Channel address |
| bus_data_o | output | CODE_W (12) | Data driven toward the converter |
| bus_data_oe_o | output | 1 | Data output enable |
| bus_data_i | input | CODE_W (12) | Data returned by the converter |
| bus_ld_no | output | 1 | Active-low load strobe |
| bus_rst_no | output | 1 | Active-low converter reset |

## Verification
The embedded properties assume the command fields are known whenever valid is high. They also assume that the bus input only needs to be meaningful while a read-back holds chip select low. They make no assumption about valid being held until ready. The bench deliberately waves valid during a busy write to show that the request is dropped. The bench drives commands on the falling clock edge and keeps each field steady until the accepting edge has passed. Its converter model returns a marker value whenever chip select is high, so a read-back sample taken outside the low window would show up as a mismatch.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_RESET = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_DONE  = 2'd2
    } st_e;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacbus_lensel.sv
module dacbus_lensel
    import dacbus_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int WR_CYC  = 19,
    parameter int RD_CYC  = 22,
    parameter int LD_CYC  = 22,
    parameter int RST_CYC = 25
) (
    input  op_e              op_i,
    input  logic             single_i,
    output logic [CNT_W-1:0] len_o
);

    localparam int SB_CYC = max2(WR_CYC, LD_CYC);

    always_comb begin
        case (op_i)
            OP_WRITE: len_o = single_i ? CNT_W'(SB_CYC) : CNT_W'(WR_CYC);
            OP_READ:  len_o = CNT_W'(RD_CYC);
            OP_LOAD:  len_o = CNT_W'(LD_CYC);
            default:  len_o = CNT_W'(RST_CYC);
        endcase
    end

endmodule

// File: rtl/dacbus_timer.sv
module dacbus_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = len_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CNT_W'(1));

    AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> (cnt_q == '0)); // R2

    AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> (len_i != '0)); // R3

endmodule

// File: rtl/dacbus_seq.sv
module dacbus_seq
    import dacbus_pkg::*;
#(
    parameter int CLK_NS  = 8,
    parameter int WR_NS   = 150,
    parameter int RD_NS   = 170,
    parameter int LD_NS   = 170,
    parameter int RST_CYC = 25,
    parameter int CODE_W  = 12,
    parameter int CH_W    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [1:0]        cmd_op_i,
    input  logic [CH_W-1:0]   cmd_ch_i,
    input  logic [CODE_W-1:0] cmd_code_i,
    input  logic              cmd_single_i,
    output logic              done_o,
    output logic [CODE_W-1:0] rd_data_o,
    output logic              bus_cs_no,
    output logic              bus_rw_o,
    output logic [CH_W-1:0]   bus_addr_o,
    output logic [CODE_W-1:0] bus_data_o,
    output logic              bus_data_oe_o,
    input  logic [CODE_W-1:0] bus_data_i,
    output logic              bus_ld_no,
    output logic              bus_rst_no
);

    localparam int WR_CYC  = ns_to_cyc(WR_NS, CLK_NS);
    localparam int RD_CYC  = ns_to_cyc(RD_NS, CLK_NS);
    localparam int LD_CYC  = ns_to_cyc(LD_NS, CLK_NS);
    localparam int MAX_CYC = max2(max2(WR_CYC, RD_CYC), max2(LD_CYC, RST_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        st_e               st;
        logic              cs_n;
        logic              ld_n;
        logic              rst_n;
        logic              rw;
        logic              oe;
        logic [CH_W-1:0]   addr;
        logic [CODE_W-1:0] dout;
        logic [CODE_W-1:0] rd;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        st:    ST_IDLE,
        cs_n:  1'b1,
        ld_n:  1'b1,
        rst_n: 1'b1,
        rw:    1'b1,
        oe:    1'b0,
        addr:  '0,
        dout:  '0,
        rd:    '0,
        done:  1'b0
    };

    seq_t             s_d, s_q;
    op_e              op;
    logic             accept;
    logic             t_last;
    logic [CNT_W-1:0] t_len;

    assign op          = op_e'(cmd_op_i);
    assign cmd_ready_o = (s_q.st == ST_IDLE);
    assign accept      = cmd_valid_i && cmd_ready_o;

    dacbus_lensel #(
        .CNT_W   (CNT_W),
        .WR_CYC  (WR_CYC),
        .RD_CYC  (RD_CYC),
        .LD_CYC  (LD_CYC),
        .RST_CYC (RST_CYC)
    ) u_lensel (
        .op_i     (op),
        .single_i (cmd_single_i),
        .len_o    (t_len)
    );

    dacbus_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (accept),
        .len_i   (t_len),
        .last_o  (t_last)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (accept) begin
                    s_d.st   = ST_PULSE;
                    s_d.addr = cmd_ch_i;
                    s_d.dout = cmd_code_i;
                    case (op)
                        OP_WRITE: begin
                            s_d.cs_n = 1'b0;
                            s_d.rw   = 1'b0;
                            s_d.oe   = 1'b1;
                            s_d.ld_n = ~cmd_single_i;
                        end
                        OP_READ: begin
                            s_d.cs_n = 1'b0;
                            s_d.rw   = 1'b1;
                            s_d.oe   = 1'b0;
                        end
                        OP_LOAD: begin
                            s_d.ld_n = 1'b0;
                        end
                        default: begin
                            s_d.rst_n = 1'b0;
                        end
                    endcase
                end
            end
            ST_PULSE: begin
                if (t_last) begin
                    if (!s_q.cs_n && s_q.rw) begin
                        s_d.rd = bus_data_i;
                    end
                    s_d.cs_n  = 1'b1;
                    s_d.ld_n  = 1'b1;
                    s_d.rst_n = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.st    = ST_DONE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
                s_d.rw = 1'b1;
                s_d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= SEQ_RESET;
        else         s_q <= s_d;
    end

    assign done_o        = s_q.done;
    assign rd_data_o     = s_q.rd;
    assign bus_cs_no     = s_q.cs_n;
    assign bus_rw_o      = s_q.rw;
    assign bus_addr_o    = s_q.addr;
    assign bus_data_o    = s_q.dout;
    assign bus_data_oe_o = s_q.oe;
    assign bus_ld_no     = s_q.ld_n;
    assign bus_rst_no    = s_q.rst_n;

    AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8

    AST_DONE_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (bus_cs_no && bus_ld_no && bus_rst_no)); // R8

    AST_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_cs_no && !$past(bus_cs_no)) |->
            ($stable(bus_addr_o) && $stable(bus_rw_o) && $stable(bus_data_o))); // R9

    AST_RESET_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_rst_no |-> (bus_cs_no && bus_ld_no)); // R7

    AST_READ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_cs_no && bus_rw_o) |-> !bus_data_oe_o); // R5

    AST_LOAD_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_ld_no |-> (bus_cs_no || !bus_rw_o)); // R6

endmodule

// File: tb/sim_dacbus_seq.sv
module sim_dacbus_seq;

    localparam int CLK_NS  = 8;
    localparam int WR_NS   = 150;
    localparam int RD_NS   = 170;
    localparam int LD_NS   = 170;
    localparam int RST_CYC = 25;
    localparam int WRC     = (WR_NS + CLK_NS - 1) / CLK_NS;
    localparam int RDC     = (RD_NS + CLK_NS - 1) / CLK_NS;
    localparam int LDC     = (LD_NS + CLK_NS - 1) / CLK_NS;
    localparam int SBC     = (WRC > LDC) ? WRC : LDC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_ch = 2'd0;
    logic [11:0] cmd_code = 12'd0;
    logic        cmd_single = 1'b0;
    logic        done;
    logic [11:0] rd_data;
    logic        cs_n, rw, oe, ld_n, crst_n;
    logic [1:0]  addr;
    logic [11:0] dout, din;

    always #4 clk = ~clk;

    dacbus_seq #(
        .CLK_NS(CLK_NS), .WR_NS(WR_NS), .RD_NS(RD_NS), .LD_NS(LD_NS),
        .RST_CYC(RST_CYC), .CODE_W(12), .CH_W(2)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_op_i(cmd_op), .cmd_ch_i(cmd_ch), .cmd_code_i(cmd_code),
        .cmd_single_i(cmd_single),
        .done_o(done), .rd_data_o(rd_data),
        .bus_cs_no(cs_n), .bus_rw_o(rw), .bus_addr_o(addr),
        .bus_data_o(dout), .bus_data_oe_o(oe), .bus_data_i(din),
        .bus_ld_no(ld_n), .bus_rst_no(crst_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // converter model: staged and output registers
    logic [11:0] in_m [4];
    logic [11:0] out_m [4];
    logic [11:0] shadow [4];

    assign din = (!cs_n && rw) ? in_m[addr] : 12'hBAD;

    typedef struct {
        int op; int ch; int code; int cs_w; int ld_w; int rst_w; int rd;
    } exp_t;
    exp_t exp_q[$];

    int cs_cnt = 0, ld_cnt = 0, rst_cnt = 0;
    logic cap_rw, cap_oe;
    logic [1:0] cap_addr;
    logic [11:0] cap_dout;
    bit prev_low = 1'b0;

    initial begin
        for (int i = 0; i < 4; i++) begin
            in_m[i] = 12'h000; out_m[i] = 12'h000; shadow[i] = 12'h000;
        end
    end

    // monitor: measures strobes, updates the converter model, compares at done
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n) begin
                if (cs_cnt == 0) begin
                    cap_rw = rw; cap_addr = addr; cap_dout = dout; cap_oe = oe;
                end
                cs_cnt++;
            end
            if (!ld_n) ld_cnt++;
            if (!crst_n) rst_cnt++;
            if (!crst_n) begin
                for (int i = 0; i < 4; i++) begin in_m[i] = 12'h800; out_m[i] = 12'h800; end
            end else begin
                if (!cs_n && !rw) in_m[addr] = dout;
                if (!ld_n) for (int i = 0; i < 4; i++) out_m[i] = in_m[i];
            end
            if (done) begin
                check(prev_low, "R8 done follows strobe", int'(prev_low), 1);
                check(cs_n && ld_n && crst_n, "R8 strobes high at done",
                      {cs_n, ld_n, crst_n}, 7);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 done without accepted command", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    case (e.op)
                        0: begin
                            check(cs_cnt == e.cs_w, e.ld_w != 0 ? "R4 cs width" : "R3 cs width", cs_cnt, e.cs_w);
                            check(ld_cnt == e.ld_w, e.ld_w != 0 ? "R4 load width" : "R3 load held high", ld_cnt, e.ld_w);
                            check(cap_rw == 1'b0, "R3 direction write", cap_rw, 0);
                            check(cap_oe == 1'b1, "R3 data enabled", cap_oe, 1);
                            check(cap_addr == e.ch[1:0], "R3 address", cap_addr, e.ch);
                            check(cap_dout == e.code[11:0], "R3 data", cap_dout, e.code);
                        end
                        1: begin
                            check(cs_cnt == e.cs_w, "R5 cs width", cs_cnt, e.cs_w);
                            check(ld_cnt == 0, "R5 load high", ld_cnt, 0);
                            check(cap_rw == 1'b1, "R5 direction read", cap_rw, 1);
                            check(cap_oe == 1'b0, "R5 bus released", cap_oe, 0);
                            check(cap_addr == e.ch[1:0], "R5 address", cap_addr, e.ch);
                            check(rd_data == e.rd[11:0], "R5 readback data", rd_data, e.rd);
                        end
                        2: begin
                            check(ld_cnt == e.ld_w, "R6 load width", ld_cnt, e.ld_w);
                            check(cs_cnt == 0, "R6 cs high", cs_cnt, 0);
                        end
                        default: begin
                            check(rst_cnt == e.rst_w, "R7 reset width", rst_cnt, e.rst_w);
                            check(cs_cnt == 0 && ld_cnt == 0, "R7 others high", cs_cnt + ld_cnt, 0);
                        end
                    endcase
                end
                cs_cnt = 0; ld_cnt = 0; rst_cnt = 0;
            end
            prev_low = !cs_n || !ld_n || !crst_n;
        end
    end

    // driver: pushes the expected item and presents the command
    task automatic send(input int op, input int ch, input int code, input bit single);
        exp_t e;
        e.op = op; e.ch = ch; e.code = code; e.rd = 0;
        e.cs_w = 0; e.ld_w = 0; e.rst_w = 0;
        case (op)
            0: begin e.cs_w = single ? SBC : WRC; e.ld_w = single ? SBC : 0; end
            1: begin e.cs_w = RDC; e.rd = int'(shadow[ch]); end
            2: e.ld_w = LDC;
            default: e.rst_w = RST_CYC;
        endcase
        if (op == 0) shadow[ch] = code[11:0];
        if (op == 3) for (int i = 0; i < 4; i++) shadow[i] = 12'h800;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_ch = ch[1:0];
        cmd_code = code[11:0]; cmd_single = single;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R2 ready low after accept", cmd_ready, 0);
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs high", cs_n, 1);
        check(ld_n == 1'b1, "R1 load high", ld_n, 1);
        check(crst_n == 1'b1, "R1 reset line high", crst_n, 1);
        check(rw == 1'b1 && oe == 1'b0, "R1 direction and enable", {rw, oe}, 2);
        check(done == 1'b0 && rd_data == 12'h0, "R1 done and data", {done, rd_data}, 0);
        check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 converter reset brings every output to midscale
        send(3, 0, 0, 1'b0);
        wait_idle();
        for (int i = 0; i < 4; i++) check(out_m[i] == 12'h800, "R7 outputs midscale", out_m[i], 12'h800);
        send(1, 2, 0, 1'b0);
        wait_idle();

        // R3 double-buffered writes leave the outputs untouched until R6 load
        send(0, 0, 12'h111, 1'b0);
        send(0, 1, 12'h222, 1'b0);
        send(0, 2, 12'h333, 1'b0);
        send(0, 3, 12'h444, 1'b0);
        wait_idle();
        for (int i = 0; i < 4; i++) check(out_m[i] == 12'h800, "R3 output held", out_m[i], 12'h800);
        send(2, 0, 0, 1'b0);
        wait_idle();
        check(out_m[0] == 12'h111 && out_m[3] == 12'h444, "R6 outputs updated",
              {out_m[0], out_m[3]}, {12'h111, 12'h444});

        // R4 single-buffered write updates the output immediately
        send(0, 1, 12'hFFF, 1'b1);
        wait_idle();
        check(out_m[1] == 12'hFFF, "R4 output follows", out_m[1], 12'hFFF);

        // R5 read-back of every channel
        for (int c = 0; c < 4; c++) send(1, c, 0, 1'b0);
        wait_idle();

        // R2 command raised while busy is ignored
        send(0, 3, 12'h123, 1'b0);
        cmd_valid = 1'b1; cmd_op = 2'd2;
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        check(out_m[3] == 12'h444, "R2 load while busy ignored", out_m[3], 12'h444);

        // boundary codes, R9 stability is covered by the bench model and properties
        send(0, 0, 12'h000, 1'b0);
        send(0, 2, 12'hFFF, 1'b1);
        send(1, 0, 0, 1'b0);
        send(1, 2, 0, 1'b0);
        send(1, 3, 0, 1'b0);
        wait_idle();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 every command completed", exp_q.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule